// File: doc/BRIEF.md
# Two-Phase Interrupt Sampling and Dispatch Unit

This block sits inside a CPU core, between the interrupt request sources and the instruction sequencer. It samples the pending request lines into a holding stage that is open during the high half of a two-phase clock cycle and closed during the low half. From the held requests that are also enabled, it picks the one with the highest priority. During the writeback slot it presents a vector address for that source. It then acknowledges that source, and only that source, in the same writeback slot of the dispatch step.

The two phases are modelled as one synchronous clock plus a phase flag. While `phase_hi` is set, the held view follows `irq_req` combinationally and is stored on every clock edge. While it is clear, the stored copy is frozen. A halted CPU leaves `phase_hi` set, so requests that arrive during a halt are still picked up.

The priority-select stage imitates precharged dynamic logic: its outputs are zero unless `writeback` is high. The acknowledge is gated by the same strobe. The sequencer must only raise `writeback` in the low phase. Because of that rule, the held request cannot be cleared by its own acknowledge before the vector has been read. If it were cleared early, the vector would collapse to 0x0000.

Top module: `irq_dispatch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stored request copy clears to zero. After such a reset, with `phase_hi` low, `irq_pending` is 0 whatever `irq_req` carries.
- R2: While `phase_hi` is high, the held request view equals `irq_req` in the same cycle, and the clock edge stores it.
- R3: While `phase_hi` is low, the held view keeps the value stored at the last high-phase edge, and changes on `irq_req` have no effect on any output.
- R4: While `writeback` is low, `irq_ack` is all zero and `vec_addr` is 0x0000.
- R5: Priority is fixed: bit 0 of `irq_req` is the highest. Only the lowest-numbered bit set in (held requests AND `irq_en`) is selected, and masked sources are never selected.
- R6: During `writeback`, `vec_addr` is 0x0040 + 8 × index of the selected source, and 0x0000 when no source is selected.
- R7: `irq_ack` is one-hot on the selected source when `dispatch` and `writeback` are both high, and all zero otherwise. At most one bit is ever set.
- R8: When `phase_hi` is held high for many cycles (halt), a request raised part way through is captured and then dispatched after the phase drops.
- R9: `irq_pending` is the OR of (held requests AND `irq_en`), independent of `writeback` and `dispatch`.
- R10: `writeback` must only be raised while `phase_hi` is low, so `irq_ack` never asserts in the high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; each edge ends one phase slot |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_hi | input | 1 | High phase flag; request holding stage is open while set |
| writeback | input | 1 | Writeback slot strobe; enables select and acknowledge |
| dispatch | input | 1 | Sequencer is in the interrupt dispatch step |
| irq_req | input | 5 | Pending request lines, bit 0 highest priority |
| irq_en | input | 5 | Per-source enable mask |
| irq_ack | output | 5 | One-hot acknowledge to the selected source |
| vec_addr | output | 16 | Dispatch vector address |
| irq_pending | output | 1 | Some enabled request is held |

## Verification
The hard case to reach from the ports is a request line that changes after the phase has dropped but before the writeback read. A faulty holding stage would let the new value leak into the vector or the acknowledge. The sweep therefore captures every request pattern under every enable mask in a high-phase cycle, and then drives the bitwise complement during the low phase before opening writeback. The halt case keeps the phase high for a run of cycles, raises a request in the middle of that run, and only then releases the phase.

// File: rtl/irq_pkg.sv
// Package: shared defaults and helpers for the interrupt dispatch unit.
// Assumes: source count is at least 2 and vector stride is a power of two.
package irq_pkg;
    parameter int unsigned IRQ_SRC_DEF    = 5;
    parameter int unsigned IRQ_ADDR_W_DEF = 16;
    parameter int unsigned IRQ_VBASE_DEF  = 32'h0040;
    parameter int unsigned IRQ_VSTEP_LG2  = 3;

    // Returns the address of a vector slot from its source index.
    function automatic logic [31:0] slot_addr(input int unsigned base,
                                              input int unsigned idx,
                                              input int unsigned step_lg2);
        return 32'(base) + (32'(idx) << step_lg2);
    endfunction
endpackage

// File: rtl/irq_sample_latch.sv
// Module: request holding stage, emulating a phase-transparent latch with a
// flop. The view follows the inputs while phase_hi is set and shows the copy
// stored at the last edge otherwise.
// Assumes: phase_hi is synchronous to clk; reset is synchronous active-low.
module irq_sample_latch #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         phase_hi,
    input  logic [N-1:0] req_in,
    output logic [N-1:0] held_view
);
    logic [N-1:0] held_q;

    // Transparent path in the high phase, frozen copy in the low phase.
    always_comb begin
        held_view = phase_hi ? req_in : held_q;
    end

    // Store the current view on every edge so the low phase replays it.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_view;
    end

    // R3: low phase keeps the view from the previous cycle
    a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_hi && $past(rst_n)) |-> held_view == $past(held_view));

    // R2: a high-phase cycle followed by a low one shows the sampled request
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase_hi) && $past(rst_n) && !phase_hi) |-> held_view == $past(req_in));
endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority selector with precharge-style gating. Outputs are
// forced low outside writeback, otherwise one-hot on the lowest set candidate.
// Assumes: bit 0 is the highest priority.
module irq_prio_pick #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evaluate,
    input  logic [N-1:0] held,
    input  logic [N-1:0] enable,
    output logic [N-1:0] sel,
    output logic         any_cand
);
    logic [N-1:0] cand;
    logic [N:0]   blocked;
    logic [N-1:0] pick;

    // Only enabled held requests compete.
    always_comb begin
        cand     = held & enable;
        any_cand = |cand;
    end

    assign blocked[0] = 1'b0;
    for (genvar gi = 0; gi < N; gi++) begin : g_chain
        // Each stage wins if it is set and nothing above it has won.
        assign pick[gi]      = cand[gi] & ~blocked[gi];
        assign blocked[gi+1] = blocked[gi] | cand[gi];
    end

    // Precharge: zero unless in the evaluate (writeback) window.
    always_comb begin
        sel = evaluate ? pick : '0;
    end

    // R5: never more than one source selected
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R5: a selected source is always enabled
    a_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sel & ~enable) == '0);
endmodule

// File: rtl/irq_vector_enc.sv
// Module: converts the one-hot selection into a vector address.
// Assumes: sel is one-hot or zero; zero maps to address 0.
module irq_vector_enc #(
    parameter int unsigned N        = 5,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned VBASE    = 32'h0040,
    parameter int unsigned STEP_LG2 = 3
) (
    input  logic [N-1:0]      sel,
    output logic [ADDR_W-1:0] vec
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] idx;

    // OR-reduce index bits from the one-hot selection.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) idx = idx | IDX_W'(i);
        end
    end

    // Base plus stride times index, or zero with no selection.
    always_comb begin
        if (|sel) vec = ADDR_W'(irq_pkg::slot_addr(VBASE, 32'(idx), STEP_LG2));
        else      vec = '0;
    end
endmodule

// File: rtl/irq_ack_gate.sv
// Module: acknowledge gating. A source is acknowledged only when selected,
// in the dispatch step, and inside writeback.
// Assumes: writeback is raised only in the low phase by the sequencer.
module irq_ack_gate #(
    parameter int unsigned N = 5
) (
    input  logic         sel_in,
    input  logic [N-1:0] sel,
    input  logic         writeback,
    output logic [N-1:0] ack
);
    // Broadcast the step and writeback bits across the selection vector.
    always_comb begin
        ack = sel & {N{sel_in}} & {N{writeback}};
    end
endmodule

// File: rtl/irq_dispatch_unit.sv
// Module: top of the interrupt dispatch unit. Samples requests in the high
// phase, selects and vectors during writeback, acknowledges in dispatch.
// Assumes: writeback and phase_hi are never high together.
module irq_dispatch_unit #(
    parameter int unsigned N        = irq_pkg::IRQ_SRC_DEF,
    parameter int unsigned ADDR_W   = irq_pkg::IRQ_ADDR_W_DEF,
    parameter int unsigned VBASE    = irq_pkg::IRQ_VBASE_DEF,
    parameter int unsigned STEP_LG2 = irq_pkg::IRQ_VSTEP_LG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_hi,
    input  logic              writeback,
    input  logic              dispatch,
    input  logic [N-1:0]      irq_req,
    input  logic [N-1:0]      irq_en,
    output logic [N-1:0]      irq_ack,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              irq_pending
);
    logic [N-1:0] held_view;
    logic [N-1:0] sel;

    irq_sample_latch #(.N(N)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_hi  (phase_hi),
        .req_in    (irq_req),
        .held_view (held_view)
    );

    irq_prio_pick #(.N(N)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .evaluate (writeback),
        .held     (held_view),
        .enable   (irq_en),
        .sel      (sel),
        .any_cand (irq_pending)
    );

    irq_vector_enc #(.N(N), .ADDR_W(ADDR_W), .VBASE(VBASE), .STEP_LG2(STEP_LG2)) u_vec (
        .sel (sel),
        .vec (vec_addr)
    );

    irq_ack_gate #(.N(N)) u_ack (
        .sel_in    (dispatch),
        .sel       (sel),
        .writeback (writeback),
        .ack       (irq_ack)
    );

    // R10: sequencer contract, writeback only in the low phase
    a_r10_wb_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        writeback |-> !phase_hi);

    // R4: outside writeback nothing is acknowledged and the vector is zero
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !writeback |-> (irq_ack == '0 && vec_addr == '0));

    // R7: an acknowledge always comes with a live vector and the dispatch step
    a_r7_ack_has_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> (dispatch && vec_addr != '0));

    // R9: with nothing pending there is nothing to vector
    a_r9_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> (vec_addr == '0 && irq_ack == '0));
endmodule

// File: tb/tb_irq_dispatch_unit.sv
`timescale 1ns/100ps
module tb_irq_dispatch_unit;
    localparam int N = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_hi = 1'b0;
    logic        writeback = 1'b0;
    logic        dispatch = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_en = '0;
    logic [N-1:0] irq_ack;
    logic [15:0]  vec_addr;
    logic         irq_pending;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_dispatch_unit dut (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .writeback(writeback),
        .dispatch(dispatch), .irq_req(irq_req), .irq_en(irq_en),
        .irq_ack(irq_ack), .vec_addr(vec_addr), .irq_pending(irq_pending)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int low_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] exp_vec(input logic [N-1:0] v);
        int k = low_idx(v);
        return (k < 0) ? 16'h0000 : 16'(16'h0040 + 8 * k);
    endfunction

    function automatic logic [N-1:0] exp_sel(input logic [N-1:0] v);
        int k = low_idx(v);
        return (k < 0) ? '0 : N'(1 << k);
    endfunction

    // Drive at the falling edge, sample 1 ns later, before the next rising edge.
    task automatic drive(input logic ph, input logic wb, input logic dp,
                         input logic [N-1:0] rq, input logic [N-1:0] en);
        @(negedge clk);
        phase_hi = ph; writeback = wb; dispatch = dp; irq_req = rq; irq_en = en;
        #1;
    endtask

    initial begin
        // R1: reset with requests present and phase low
        drive(1'b0, 1'b0, 1'b0, 5'h1F, 5'h1F);
        drive(1'b0, 1'b0, 1'b0, 5'h1F, 5'h1F);
        chk("R1 pending after reset", 32'(irq_pending), 32'd0);
        chk("R1 ack after reset", 32'(irq_ack), 32'd0);
        chk("R1 vector after reset", 32'(vec_addr), 32'd0);
        rst_n = 1'b1;
        drive(1'b0, 1'b1, 1'b1, 5'h1F, 5'h1F);
        chk("R1 held cleared, no vector", 32'(vec_addr), 32'd0);

        // R2..R7, R9: sweep every request pattern under every mask
        for (int r = 0; r < 32; r++) begin
            for (int m = 0; m < 32; m++) begin
                logic [N-1:0] rq = N'(r);
                logic [N-1:0] en = N'(m);
                logic [N-1:0] cand = rq & en;
                drive(1'b1, 1'b0, 1'b0, rq, en);
                chk("R2 transparent pending", 32'(irq_pending), 32'(|cand));
                chk("R4 no vector outside writeback", 32'(vec_addr), 32'd0);
                drive(1'b0, 1'b0, 1'b1, ~rq, en);
                chk("R3 held against changed input", 32'(irq_pending), 32'(|cand));
                chk("R4 no ack outside writeback", 32'(irq_ack), 32'd0);
                drive(1'b0, 1'b1, 1'b0, ~rq, en);
                chk("R6 vector in writeback", 32'(vec_addr), 32'(exp_vec(cand)));
                chk("R7 no ack without dispatch", 32'(irq_ack), 32'd0);
                drive(1'b0, 1'b1, 1'b1, ~rq, en);
                chk("R5 R7 ack one-hot on winner", 32'(irq_ack), 32'(exp_sel(cand)));
                chk("R9 pending in writeback", 32'(irq_pending), 32'(|cand));
            end
        end

        // R8: halt keeps phase high; request appears part way through
        for (int c = 0; c < 10; c++) begin
            drive(1'b1, 1'b0, 1'b0, (c >= 5) ? 5'b01000 : 5'b00000, 5'h1F);
            if (c == 4) chk("R8 nothing yet during halt", 32'(irq_pending), 32'd0);
        end
        chk("R8 captured during halt", 32'(irq_pending), 32'd1);
        drive(1'b0, 1'b0, 1'b0, 5'b00000, 5'h1F);
        drive(1'b0, 1'b1, 1'b1, 5'b00000, 5'h1F);
        chk("R8 halt request vector", 32'(vec_addr), 32'h0058);
        chk("R8 halt request ack", 32'(irq_ack), 32'b01000);

        // R10: high phase with dispatch but no writeback gives no ack
        drive(1'b1, 1'b0, 1'b1, 5'h01, 5'h1F);
        chk("R10 no ack in high phase", 32'(irq_ack), 32'd0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule